// File: doc/BRIEF.md
# Power-Management Event Register Pair

This block holds two 16-bit registers for a platform power-management controller: an event status word and an event enable word. Both sit on a simple strobe-based I/O bus with an address, separate write and read strobes, a byte-count field and 16-bit write and read data. The status word sits at the base address and the enable word two bytes above it. A power-button pulse input records a button event in the status word. Software acknowledges events by writing ones to the status bits it wants cleared. The enable word keeps only the bits that have a working source.

The block drives a level-sensitive system control interrupt. The interrupt stays high for as long as any interrupt-capable event has both its status bit and its enable bit set. The interrupt is evaluated again from the registered state after every change. Event sources other than the power button have no input here, so their status bits never become set.

Top module: `pm_evt_regs`

## Requirements
- R1: After reset, status and enable both read 0x0000, `sci_out` is low and `bus_err` is low. Asserting `rst_n` low forces `sci_out` low at once, without waiting for a clock edge.
- R2: When `pwr_btn_evt` is high in a cycle, status bit 8 reads as 1 from the next cycle on. A further event while the bit is already set leaves the register at the same value.
- R3: A 2-byte write to the status address clears each of status bits 15, 10, 9, 8 and 4 whose write-data bit is 1. Status bits whose write-data bit is 0, and bits 0 and 5 in all cases, keep their value.
- R4: A 2-byte write to the enable address stores write-data bits 8 and 5 and forces every other enable bit to 0. Writing 0xFFFF therefore reads back as 0x0120.
- R5: `sci_out` is high exactly when, in the previous cycle, at least one of bit positions 0, 5, 8, 9 and 10 was set in both status and enable. It follows a register change by one clock.
- R6: `sci_out` is a level output. It stays high over idle cycles and over reads until the enabling condition is removed, either by clearing the status bit or by clearing the enable bit.
- R7: If a power-button event and a status write that clears bit 8 fall in the same cycle, bit 8 remains set.
- R8: An access to either register whose `bus_size` is not 2 (the field holds the access width in bytes, with 0 meaning 4) raises `bus_err` for one cycle, in the cycle after the strobe. Such an access changes no register and leaves `bus_rdata` as it was.
- R9: Status decodes at `BASE_ADDR` and enable at `BASE_ADDR`+2. Accesses to any other address are ignored and never raise `bus_err`.
- R10: The value of a register read appears on `bus_rdata` in the cycle after the read strobe. `bus_rdata` holds that value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W (16) | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 2 | Access width in bytes (0 means 4) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse flagging a rejected access size |
| pwr_btn_evt | input | 1 | Power-button event pulse |
| sci_out | output | 1 | Level-sensitive system control interrupt |

## Verification
A corrupted status or enable bit appears at `sci_out` one clock after it goes wrong, but only when the matching bit in the other register is set. The bench therefore arms the power-button enable before it probes the clearing rules. A register that stores an unsupported enable bit, or that clears a protected status bit, shows up in the read data one cycle after the next read strobe. A faulty size or address decode shows up either as a missing `bus_err` pulse in the cycle after the access or as a register value that has changed when it should not.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int DATA_W    = 16;
  localparam int SIZE_W    = 2;
  localparam int ACC_BYTES = 2;

  localparam int B_TMR  = 0;
  localparam int B_BM   = 4;
  localparam int B_GBL  = 5;
  localparam int B_PWR  = 8;
  localparam int B_SLP  = 9;
  localparam int B_RTC  = 10;
  localparam int B_WAK  = 15;

  // status bits software may acknowledge by writing a one
  localparam logic [DATA_W-1:0] STS_ACK_MASK =
    (DATA_W'(1) << B_WAK) | (DATA_W'(1) << B_RTC) | (DATA_W'(1) << B_SLP) |
    (DATA_W'(1) << B_PWR) | (DATA_W'(1) << B_BM);
  // enable bits that are retained on a write
  localparam logic [DATA_W-1:0] EN_KEEP_MASK =
    (DATA_W'(1) << B_PWR) | (DATA_W'(1) << B_GBL);
  // bit positions that can raise the interrupt
  localparam logic [DATA_W-1:0] SCI_SRC_MASK =
    (DATA_W'(1) << B_TMR) | (DATA_W'(1) << B_GBL) | (DATA_W'(1) << B_PWR) |
    (DATA_W'(1) << B_SLP) | (DATA_W'(1) << B_RTC);
endpackage

// File: rtl/pm_bus_decode.sv
module pm_bus_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr,
  input  logic                         rd,
  input  logic [pm_evt_pkg::SIZE_W-1:0] size,
  output logic                         sts_wr,
  output logic                         sts_rd,
  output logic                         en_wr,
  output logic                         en_rd,
  output logic                         bad_acc
);
  import pm_evt_pkg::*;

  localparam logic [ADDR_W-1:0] EN_ADDR = BASE_ADDR + ADDR_W'(2);

  logic hit_sts, hit_en, size_ok;

  always_comb begin
    hit_sts = (addr == BASE_ADDR);
    hit_en  = (addr == EN_ADDR);
    size_ok = (size == SIZE_W'(ACC_BYTES));
    sts_wr  = hit_sts & wr & size_ok;
    sts_rd  = hit_sts & rd & size_ok;
    en_wr   = hit_en  & wr & size_ok;
    en_rd   = hit_en  & rd & size_ok;
    bad_acc = (hit_sts | hit_en) & (wr | rd) & ~size_ok;
  end
endmodule

// File: rtl/pm_sts_reg.sv
module pm_sts_reg (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  logic [pm_evt_pkg::DATA_W-1:0] wdata,
  input  logic                          btn_evt,
  output logic [pm_evt_pkg::DATA_W-1:0] sts_q
);
  import pm_evt_pkg::*;

  logic [DATA_W-1:0] sts_d;
  logic              sts_upd;

  always_comb begin
    sts_upd = wr_stb | btn_evt;
    sts_d   = sts_q;
    if (wr_stb) sts_d = sts_d & ~(wdata & STS_ACK_MASK);
    // the event is applied last so it wins over a same-cycle acknowledge
    if (btn_evt && !sts_q[B_PWR]) sts_d[B_PWR] = 1'b1;
    else if (btn_evt)             sts_d[B_PWR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts_q <= '0;
    else if (sts_upd) sts_q <= sts_d;
  end

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    btn_evt |=> sts_q[B_PWR]);
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata[B_PWR] && !btn_evt) |=> !sts_q[B_PWR]);
  p_keep_unacked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wdata[B_PWR] && sts_q[B_PWR]) |=> sts_q[B_PWR]);
  p_evt_beats_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata[B_PWR] && btn_evt) |=> sts_q[B_PWR]);
endmodule

// File: rtl/pm_en_reg.sv
module pm_en_reg (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  logic [pm_evt_pkg::DATA_W-1:0] wdata,
  output logic [pm_evt_pkg::DATA_W-1:0] en_q
);
  import pm_evt_pkg::*;

  logic [DATA_W-1:0] en_d;

  always_comb en_d = wdata & EN_KEEP_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_stb) en_q <= en_d;
  end

  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(en_q));
  p_en_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (en_q[B_PWR] == $past(wdata[B_PWR])));
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [pm_evt_pkg::DATA_W-1:0] sts,
  input  logic [pm_evt_pkg::DATA_W-1:0] en,
  output logic                          sci_q
);
  import pm_evt_pkg::*;

  logic [DATA_W-1:0] armed;
  logic              sci_d;

  always_comb begin
    armed = sts & en & SCI_SRC_MASK;
    sci_d = |armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sci_q <= 1'b0;
    else        sci_q <= sci_d;
  end

  p_sci_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[B_PWR] && en[B_PWR]) |=> sci_q);
  p_sci_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & en) == '0) |=> !sci_q);
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_err,
  input  logic              pwr_btn_evt,
  output logic              sci_out
);
  import pm_evt_pkg::*;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  always_comb rst_ok_n = rst_sync[1];

  logic sts_wr, sts_rd, en_wr, en_rd, bad_acc;
  logic [DATA_W-1:0] sts_q, en_q;

  pm_bus_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .size(bus_size),
    .sts_wr(sts_wr), .sts_rd(sts_rd), .en_wr(en_wr), .en_rd(en_rd),
    .bad_acc(bad_acc)
  );

  pm_sts_reg u_sts (
    .clk(clk), .rst_n(rst_ok_n), .wr_stb(sts_wr), .wdata(bus_wdata),
    .btn_evt(pwr_btn_evt), .sts_q(sts_q)
  );

  pm_en_reg u_en (
    .clk(clk), .rst_n(rst_ok_n), .wr_stb(en_wr), .wdata(bus_wdata),
    .en_q(en_q)
  );

  pm_sci_gen u_sci (
    .clk(clk), .rst_n(rst_ok_n), .sts(sts_q), .en(en_q), .sci_q(sci_out)
  );

  // read path and error flag
  logic              rd_upd;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rd_upd  = sts_rd | en_rd;
    rdata_d = sts_rd ? sts_q : en_q;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)   bus_rdata <= '0;
    else if (rd_upd) bus_rdata <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) bus_err <= 1'b0;
    else           bus_err <= bad_acc;
  end

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rd_upd |=> $stable(bus_rdata));
  p_bad_en_stable_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    bad_acc |=> ($stable(en_q) && bus_err));
  p_bad_sts_stable_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bad_acc && !pwr_btn_evt) |=> $stable(sts_q));
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!bus_wr && !bus_rd) |=> !bus_err);
endmodule

// File: tb/sim_pm_evt_regs.sv
module sim_pm_evt_regs;
  localparam logic [15:0] BASE = 16'h0400;
  localparam logic [15:0] ENA  = BASE + 16'd2;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam int NV = 12;

  // {op[55:54], addr[53:38], size[37:36], wdata[35:20], evt[19],
  //  exp_rd[18:3], chk_rd[2], exp_err[1], exp_sci[0]}
  localparam logic [55:0] VEC [NV] = '{
    {OP_RD,   BASE,  2'd2, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
    {OP_WR,   ENA,   2'd2, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {OP_RD,   ENA,   2'd2, 16'h0000, 1'b0, 16'h0120, 1'b1, 1'b0, 1'b0},
    {OP_IDLE, 16'h0, 2'd2, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1},
    {OP_RD,   BASE,  2'd2, 16'h0000, 1'b0, 16'h0100, 1'b1, 1'b0, 1'b1},
    {OP_WR,   BASE,  2'd2, 16'hFEFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    {OP_RD,   BASE,  2'd2, 16'h0000, 1'b0, 16'h0100, 1'b1, 1'b0, 1'b1},
    {OP_WR,   ENA,   2'd2, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {OP_WR,   ENA,   2'd2, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    {OP_WR,   BASE,  2'd2, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {OP_RD,   BASE,  2'd2, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
    {OP_RD,   BASE + 16'd4, 2'd1, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, pwr_btn_evt = 1'b0;
  logic [1:0] bus_size = 2'd2;
  logic [15:0] bus_rdata;
  logic bus_err, sci_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] s_rd;
  logic s_err, s_sci;

  always #4 clk = ~clk;

  pm_evt_regs #(.ADDR_W(16), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pwr_btn_evt(pwr_btn_evt),
    .sci_out(sci_out)
  );

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1";  1: return "R4";  2: return "R4";  3: return "R2";
      4: return "R2";  5: return "R3";  6: return "R3";  7: return "R5";
      8: return "R5";  9: return "R6"; 10: return "R3";  default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access: drive before edge E, sample rdata/err after E, sci after E+1
  task automatic do_op(logic [1:0] op, logic [15:0] a, logic [1:0] sz,
                       logic [15:0] wd, logic ev);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = wd; pwr_btn_evt = ev;
    bus_wr = (op == OP_WR); bus_rd = (op == OP_RD);
    @(negedge clk);
    s_rd = bus_rdata; s_err = bus_err;
    bus_wr = 1'b0; bus_rd = 1'b0; pwr_btn_evt = 1'b0; bus_size = 2'd2;
    @(negedge clk);
    s_sci = sci_out;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 sci", {15'd0, sci_out}, 16'd0);
    check("R1 err", {15'd0, bus_err}, 16'd0);
    check("R1 rdata", bus_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      do_op(v[55:54], v[53:38], v[37:36], v[35:20], v[19]);
      if (v[2]) check({vec_tag(i), " rdata"}, s_rd, v[18:3]);
      check({vec_tag(i), " err"}, {15'd0, s_err}, {15'd0, v[1]});
      check({vec_tag(i), " sci"}, {15'd0, s_sci}, {15'd0, v[0]});
    end
    // state now: status 0, enable 0x0100, rdata 0

    // R8 wrong-size write to enable: error pulse, no change
    do_op(OP_WR, ENA, 2'd1, 16'h0000, 1'b0);
    check("R8 err on size1 write", {15'd0, s_err}, 16'd1);
    do_op(OP_RD, ENA, 2'd2, 16'h0000, 1'b0);
    check("R8 enable unchanged", s_rd, 16'h0100);
    check("R8 err cleared", {15'd0, s_err}, 16'd0);

    // R8 wrong-size read of status: error, rdata held
    do_op(OP_RD, BASE, 2'd0, 16'h0000, 1'b0);
    check("R8 err on size4 read", {15'd0, s_err}, 16'd1);
    check("R8 rdata held", s_rd, 16'h0100);

    // R7 event and acknowledge in the same cycle
    do_op(OP_IDLE, 16'h0, 2'd2, 16'h0000, 1'b1);
    check("R6 sci raised", {15'd0, s_sci}, 16'd1);
    do_op(OP_WR, BASE, 2'd2, 16'h0100, 1'b1);
    check("R7 sci stays", {15'd0, s_sci}, 16'd1);
    do_op(OP_RD, BASE, 2'd2, 16'h0000, 1'b0);
    check("R7 bit8 kept", s_rd, 16'h0100);

    // R2 repeat event while set
    do_op(OP_IDLE, 16'h0, 2'd2, 16'h0000, 1'b1);
    do_op(OP_RD, BASE, 2'd2, 16'h0000, 1'b0);
    check("R2 repeat event", s_rd, 16'h0100);

    // R10 rdata held over non-read cycles
    do_op(OP_WR, ENA, 2'd2, 16'h0020, 1'b0);
    check("R10 rdata held", s_rd, 16'h0100);
    check("R5 sci off after enable change", {15'd0, s_sci}, 16'd0);

    // R1 reset mid-run: sci drops asynchronously
    do_op(OP_WR, ENA, 2'd2, 16'h0100, 1'b0);
    check("R6 sci back", {15'd0, s_sci}, 16'd1);
    #1 rst_n = 1'b0;
    #1 check("R1 async sci", {15'd0, sci_out}, 16'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_op(OP_RD, BASE, 2'd2, 16'h0000, 1'b0);
    check("R1 status after reset", s_rd, 16'h0000);
    do_op(OP_RD, ENA, 2'd2, 16'h0000, 1'b0);
    check("R1 enable after reset", s_rd, 16'h0000);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule